// File: doc/BRIEF.md
# Flash Write-Cycle Qualifier with Supply Lockout

This block sits between the asynchronous control strobes of a NOR-flash-style device model and its command decoder. It samples chip-enable, output-enable and write-enable (all active low) in a fast system clock. Each strobe passes through a two-stage synchroniser and a glitch filter that needs a run of identical samples. The block then applies the logical inhibit rules and hands the decoder a single-cycle write strobe together with the address and data that were latched during the write.

Two further protections keep spurious writes out. A power-up inhibit blocks any write until write-enable has been seen high after reset, so a strobe that is already low at power-up cannot produce a command when it rises. A digital low-supply lockout input aborts any write in progress and blocks all writes while it is held. Each time the lockout asserts, the block raises a one-cycle request that returns the decoder to read mode. Once the lockout is released, writes are blocked until write-enable has again been seen high.

Top module: `flash_wr_qual`

## Requirements
- R1: After reset, `wr_stb` and `rd_reset` are 0, and no write is accepted until the filtered write-enable has been seen high.
- R2: A write opens only while the filtered chip-enable and write-enable are both low and the filtered output-enable is high. Once open, it closes when write-enable or chip-enable rises, and `wr_stb` then pulses for exactly one clock.
- R3: `wr_addr` and `wr_data` carry the `addr` and `data` values sampled during the open write. They hold those values after the strobe.
- R4: A pin level reaches the qualifier only after FILT_LEN consecutive identical samples at the synchroniser output. A shorter low pulse on any strobe starts no write.
- R5: If output-enable goes low while a write is open, the write is dropped and no strobe is issued.
- R6: A write-enable pulse while chip-enable is high produces no strobe.
- R7: If chip-enable and write-enable are low from reset onward, the later rise of write-enable produces no strobe. A normal write after that produces one.
- R8: The synchronised lockout drops any open write and blocks all writes while it is held. Each time it asserts, `rd_reset` pulses once for one clock.
- R9: After the lockout is released, a write-enable that was held low does not produce a strobe when it rises. Writes resume only after write-enable has been seen high.
- R10: `wr_stb` and `rd_reset` are never high on two consecutive clocks.
- R11: A write that closes on the rise of chip-enable, with write-enable still low, also produces one strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | AW | Address bus, held stable through a write |
| data | input | DW | Data bus, held stable through a write |
| lockout | input | 1 | Low-supply lockout, active high |
| wr_stb | output | 1 | One-cycle qualified write event |
| wr_addr | output | AW | Address latched for the last write |
| wr_data | output | DW | Data latched for the last write |
| rd_reset | output | 1 | One-cycle request to return to read mode |

## Verification
The assertions check on every clock that each strobe and read-mode request lasts one cycle and that a filtered level changes only after the synchroniser has presented that level. They also check that a strobe always follows an open write, and that no strobe appears while the lockout has been held. Only the bench scenarios can show the sequence-dependent behaviour: the power-up inhibit, the re-arm after lockout, a write dropped by output-enable, a write closed by chip-enable, and short pulses rejected by the filter. The bench compares these against a behavioural model on every clock.

// File: rtl/wq_pkg.sv
package wq_pkg;
  // Write window is open when chip and write enables are low and output enable is high.
  function automatic logic wq_write_cond(input logic ce_n, input logic oe_n, input logic we_n);
    return (~ce_n) & (~we_n) & oe_n;
  endfunction

  // A write closes on whichever of write-enable or chip-enable returns high.
  function automatic logic wq_close_cond(input logic ce_n, input logic we_n);
    return ce_n | we_n;
  endfunction
endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/wq_filter.sv
module wq_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          synced;
  logic [CW-1:0] run_cnt;

  wq_sync #(.RST_VAL(1'b0)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin),
    .dout (synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= 1'b0;
      run_cnt <= '0;
    end else if (synced == level) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      level   <= synced;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_LEVEL_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> level == $past(synced)); // R4
endmodule

// File: rtl/wq_ctrl.sv
module wq_ctrl
  import wq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_ce,
  input  logic          f_oe,
  input  logic          f_we,
  input  logic          lk_s,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_reset,
  output logic          active,
  output logic          inhibit
);
  logic lk_q;
  logic open_ok;
  logic close_ok;

  assign open_ok  = wq_write_cond(f_ce, f_oe, f_we);
  assign close_ok = wq_close_cond(f_ce, f_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      inhibit  <= 1'b1;
      wr_stb   <= 1'b0;
      rd_reset <= 1'b0;
      lk_q     <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb   <= 1'b0;
      rd_reset <= lk_s & ~lk_q;
      lk_q     <= lk_s;
      if (lk_s) begin
        active  <= 1'b0;
        inhibit <= 1'b1;
      end else if (inhibit) begin
        if (f_we) inhibit <= 1'b0;
      end else if (active) begin
        if (close_ok) begin
          active <= 1'b0;
          wr_stb <= 1'b1;
        end else if (!f_oe) begin
          active <= 1'b0;
        end else begin
          wr_addr <= addr;
          wr_data <= data;
        end
      end else if (open_ok) begin
        active  <= 1'b1;
        wr_addr <= addr;
        wr_data <= data;
      end
    end
  end

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R10
  AST_RDRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_reset |=> !rd_reset); // R10
  AST_STB_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(active)); // R2
  AST_NO_STB_IN_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_s && $past(lk_s)) |-> !wr_stb); // R8
  AST_NO_OPEN_WHILE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inhibit) |-> !$rose(active)); // R7
endmodule

// File: rtl/flash_wr_qual.sv
module flash_wr_qual #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int FILT_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          lockout,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_reset
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pins;
  logic [NPIN-1:0] levels;
  logic            lk_s;
  logic            active;
  logic            inhibit;

  assign pins = {we_n, oe_n, ce_n};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    wq_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pins[g]),
      .level(levels[g])
    );
  end

  wq_sync #(.RST_VAL(1'b0)) u_lk_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (lockout),
    .dout (lk_s)
  );

  wq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .f_ce    (levels[0]),
    .f_oe    (levels[1]),
    .f_we    (levels[2]),
    .lk_s    (lk_s),
    .addr    (addr),
    .data    (data),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_reset(rd_reset),
    .active  (active),
    .inhibit (inhibit)
  );

  AST_RDRST_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_reset |-> $past(lk_s)); // R8
endmodule

// File: tb/flash_wr_qual_bench.sv
module flash_wr_qual_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int FL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b0, lockout = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic wr_stb, rd_reset;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, errors = 0, stb_cnt = 0, rr_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_wr_qual #(.AW(AW), .DW(DW), .FILT_LEN(FL)) u_flash_wr_qual (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .data(data), .lockout(lockout),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .rd_reset(rd_reset)
  );

  // Behavioural reference: pin history, run lengths and a small mode variable.
  int hist[3][$];
  int level[3];
  int runlen[3];
  int lk_hist[$];
  int lk_prev, mode, armed, m_stb, m_rr;
  int m_addr, m_data;

  function automatic int pin_val(int i);
    return (i == 0) ? int'(ce_n) : (i == 1) ? int'(oe_n) : int'(we_n);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        hist[i] = {0, 0};
        level[i] = 0;
        runlen[i] = 0;
      end
      lk_hist = {0, 0};
      lk_prev = 0; mode = 0; armed = 0; m_stb = 0; m_rr = 0; m_addr = 0; m_data = 0;
    end else begin
      int lk_now;
      int ce_l, oe_l, we_l;
      lk_now = lk_hist[1];
      ce_l = level[0]; oe_l = level[1]; we_l = level[2];
      m_stb = 0;
      m_rr = (lk_now == 1 && lk_prev == 0) ? 1 : 0;
      lk_prev = lk_now;
      if (lk_now == 1) begin
        mode = 0; armed = 0;
      end else if (armed == 0) begin
        if (we_l == 1) armed = 1;
      end else if (mode == 1) begin
        if (we_l == 1 || ce_l == 1) begin mode = 0; m_stb = 1; end
        else if (oe_l == 0) mode = 0;
        else begin m_addr = int'(addr); m_data = int'(data); end
      end else if (ce_l == 0 && we_l == 0 && oe_l == 1) begin
        mode = 1; m_addr = int'(addr); m_data = int'(data);
      end
      for (int i = 0; i < 3; i++) begin
        if (hist[i][1] == level[i]) runlen[i] = 0;
        else if (runlen[i] + 1 >= FL) begin level[i] = hist[i][1]; runlen[i] = 0; end
        else runlen[i] = runlen[i] + 1;
        void'(hist[i].pop_back());
        hist[i].push_front(pin_val(i));
      end
      void'(lk_hist.pop_back());
      lk_hist.push_front(int'(lockout));
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (wr_stb) stb_cnt++;
    if (rd_reset) rr_cnt++;
    check("R10 strobe vs model", int'(wr_stb), m_stb);
    check("R8 read-reset vs model", int'(rd_reset), m_rr);
    if (wr_stb) begin
      check("R3 address vs model", int'(wr_addr), m_addr);
      check("R3 data vs model", int'(wr_data), m_data);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_op(input int a, input int d, input bit ce_first);
    @(negedge clk);
    addr = AW'(a); data = DW'(d); oe_n = 1'b1;
    ce_n = 1'b0; cyc(2);
    we_n = 1'b0; cyc(12);
    if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
    cyc(3);
    ce_n = 1'b1; we_n = 1'b1;
    cyc(14);
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int s0, r0;
    // R7: chip and write enables low from power-up
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check("R1 wr_stb after reset", int'(wr_stb), 0);
    check("R1 rd_reset after reset", int'(rd_reset), 0);
    cyc(20);
    s0 = stb_cnt;
    we_n = 1'b1; cyc(20);
    ce_n = 1'b1; cyc(10);
    check("R7 no strobe on power-up WE rise", stb_cnt - s0, 0);
    write_op(16'h1234, 16'hABCD, 0);
    check("R7 first normal write accepted", stb_cnt - s0, 1);
    check("R3 latched address", int'(wr_addr), 16'h1234);
    check("R3 latched data", int'(wr_data), 16'hABCD);

    // R2: second write, different values
    s0 = stb_cnt;
    write_op(16'h0055, 16'h0098, 0);
    check("R2 WE-closed write strobes once", stb_cnt - s0, 1);
    check("R3 address held after strobe", int'(wr_addr), 16'h0055);

    // R11: closed by chip-enable rising first
    s0 = stb_cnt;
    write_op(16'h2AAA, 16'h00F0, 1);
    check("R11 CE-closed write strobes once", stb_cnt - s0, 1);
    check("R11 CE-closed address", int'(wr_addr), 16'h2AAA);

    // R4: short low pulses on WE then CE
    s0 = stb_cnt;
    ce_n = 1'b0; cyc(2); we_n = 1'b0; cyc(FL - 2); we_n = 1'b1; cyc(15);
    ce_n = 1'b1; cyc(5);
    we_n = 1'b0; cyc(15); ce_n = 1'b0; cyc(FL - 2); ce_n = 1'b1; cyc(15);
    we_n = 1'b1; cyc(15);
    check("R4 short pulses give no strobe", stb_cnt - s0, 0);

    // R5: output enable drops during an open write
    s0 = stb_cnt;
    ce_n = 1'b0; we_n = 1'b0; cyc(12);
    oe_n = 1'b0; cyc(12);
    we_n = 1'b1; ce_n = 1'b1; cyc(15); oe_n = 1'b1; cyc(5);
    check("R5 OE low aborts write", stb_cnt - s0, 0);

    // R6: WE pulse with CE high
    s0 = stb_cnt;
    we_n = 1'b0; cyc(15); we_n = 1'b1; cyc(15);
    check("R6 CE high inhibits", stb_cnt - s0, 0);

    // R8: lockout during an open write, then writes while held
    s0 = stb_cnt; r0 = rr_cnt;
    ce_n = 1'b0; we_n = 1'b0; cyc(12);
    lockout = 1'b1; cyc(10);
    we_n = 1'b1; ce_n = 1'b1; cyc(15);
    write_op(16'h0F0F, 16'h0001, 0);
    check("R8 no strobe under lockout", stb_cnt - s0, 0);
    check("R8 one read-reset pulse", rr_cnt - r0, 1);

    // R9: WE held low across lockout release
    s0 = stb_cnt;
    ce_n = 1'b0; we_n = 1'b0; cyc(10);
    lockout = 1'b0; cyc(20);
    we_n = 1'b1; cyc(15); ce_n = 1'b1; cyc(10);
    check("R9 no strobe on re-arm edge", stb_cnt - s0, 0);
    write_op(16'h4321, 16'h5A5A, 0);
    check("R9 write accepted after re-arm", stb_cnt - s0, 1);
    check("R9 address after re-arm", int'(wr_addr), 16'h4321);

    // R8: second lockout assertion gives a second pulse
    r0 = rr_cnt;
    lockout = 1'b1; cyc(10); lockout = 1'b0; cyc(10);
    check("R8 pulse per lockout assertion", rr_cnt - r0, 1);

    done = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      done = 1;
      report();
    end
  end
endmodule